// File: doc/BRIEF.md
# IrDA Return-to-Zero Pulse Codec

This block sits between a 16x-oversampled UART shift engine and an infrared transceiver. In the transmit direction it watches the shift register's output bit together with the engine's oversample phase counter. Every zero bit becomes a narrow low pulse, three sclk16 ticks wide, placed in the middle of the bit. The line stays high for the rest of that bit and for all of every one bit.

In the receive direction the input pin is synchronized and sampled on a detection strobe. That strobe is divided down from the block clock by a power of two, chosen with a three-bit select. A low level counts as a pulse only when at least two consecutive detection samples see it. Each accepted pulse raises one event, which crosses into the sclk16 timing through a toggle. There it drives the receive bit low for exactly sixteen ticks, which is one bit time.

A single enable input switches both paths in. With the enable clear, the pins pass straight through to the shift engine. The codec works at the level of line bits and has no data items to hand over, so it has no valid/ready handshake and no back-pressure. Its signals are plain level and strobe pins. The enable and the divider select are meant to be set while the UART is idle.

Top module: `irda_rzi_codec`

## Requirements
- R1: After reset, with the receive pin high, both `tx_pin_o` and `rx_bit_o` are high.
- R2: With the enable set, a zero on `tx_bit_i` drives `tx_pin_o` low while `tx_phase_i` is 8, 9 or 10. The pin follows the phase one clock later, so the low lasts exactly 3 sclk16 ticks per zero bit, and adjacent zero bits give separate pulses.
- R3: With the enable set, a one on `tx_bit_i` keeps `tx_pin_o` high for the whole bit.
- R4: With the enable set, each accepted receive pulse drives `rx_bit_o` low for exactly 16 `tick16_i` strobes.
- R5: A low on `rx_pin_i` that is seen on fewer than 2 consecutive detection samples is ignored, and `rx_bit_o` stays high.
- R6: Select code n on `det_div_sel_i` (0 to 7) sets the detection sample rate to one clock in 2^n, that is a divide ratio of 1, 2, 4, 8, 16, 32, 64 or 128.
- R7: If a new accepted pulse arrives while a 16-tick stretch is running, the stretch restarts from 16. `rx_bit_o` stays low continuously until 16 ticks after the later pulse.
- R8: With the enable clear, `tx_pin_o` equals `tx_bit_i` and `rx_bit_o` equals `rx_pin_i` with no delay.
- R9: A receive low that lasts much longer than one bit still produces only one 16-tick stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the detection divider counts it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_en_i | input | 1 | 1 = codec active, 0 = straight pass-through |
| det_div_sel_i | input | 3 | Detection divide select, ratio 2^code |
| tick16_i | input | 1 | sclk16 strobe, one clock wide |
| tx_bit_i | input | 1 | Bit from the transmit shift register |
| tx_phase_i | input | 4 | Oversample phase (0 to 15) of the current transmit bit |
| tx_pin_o | output | 1 | Infrared transmit line |
| rx_pin_i | input | 1 | Infrared receive line, idle high |
| rx_bit_o | output | 1 | Recovered bit for the receive shift register |

## Verification
The bench uses the default parameters, which give a 3-tick window starting at phase 8, a 16-tick stretch and a two-sample qualifier. It generates a sclk16 strobe every fourth clock, so the pulse and stretch widths show up as exact clock counts of 12 and 64. It switches the detection select between codes 0, 2 and 7. At each of these ratios it drives one pulse just too short to reach two samples and one long enough to reach them, which tests the minimum-width rule at both edges. Back-to-back pulses exactly eight ticks apart make the restarted stretch a fixed 24 ticks long, so R7 can be checked exactly.

// File: rtl/irda_codec_pkg.sv
package irda_codec_pkg;
  localparam int unsigned PHASE_W = 4;
  localparam int unsigned TICKS_PER_BIT = 1 << PHASE_W;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/irda_det_prescaler.sv
module irda_det_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             strobe_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(sel_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = ((cnt_q & mask) == mask);

  // R6
  div1_every_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |-> strobe_o);
endmodule

// File: rtl/irda_tx_shaper.sv
module irda_tx_shaper
  import irda_codec_pkg::*;
#(
  parameter int unsigned PULSE_START = 8,
  parameter int unsigned PULSE_LEN   = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_i,
  input  logic   bit_i,
  input  phase_t phase_i,
  output logic   line_o
);
  localparam phase_t WIN_LO = phase_t'(PULSE_START);
  localparam phase_t WIN_HI = phase_t'(PULSE_START + PULSE_LEN - 1);

  logic in_win;
  assign in_win = (phase_i >= WIN_LO) && (phase_i <= WIN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_o <= 1'b1;
    else        line_o <= !(en_i && !bit_i && in_win);
  end

  // R2
  tx_low_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_o && $past(rst_n)) |-> $past(!bit_i));
endmodule

// File: rtl/irda_rx_qualifier.sv
module irda_rx_qualifier #(
  parameter int unsigned QUAL_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic strobe_i,
  input  logic pin_i,
  output logic event_tog_o
);
  localparam int unsigned QW = $clog2(QUAL_MIN + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_MIN - 1);
  localparam logic [QW-1:0] Q_SAT  = QW'(QUAL_MIN);

  logic [1:0]    sync_q;
  logic [QW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q   <= '0;
      event_tog_o <= 1'b0;
    end else if (!en_i) begin
      low_cnt_q <= '0;
    end else if (strobe_i) begin
      if (sync_q[1]) begin
        low_cnt_q <= '0;
      end else begin
        if (low_cnt_q == Q_LAST) event_tog_o <= ~event_tog_o;
        if (low_cnt_q != Q_SAT)  low_cnt_q <= low_cnt_q + 1'b1;
      end
    end
  end

  // R5
  qual_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_tog_o != $past(event_tog_o)) |-> ($past(!sync_q[1]) && $past(strobe_i)));
  // R9
  qual_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt_q <= Q_SAT);
endmodule

// File: rtl/irda_rx_stretcher.sv
module irda_rx_stretcher #(
  parameter int unsigned STRETCH_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic event_tog_i,
  output logic low_o
);
  localparam int unsigned CW = $clog2(STRETCH_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_TICKS);

  logic          seen_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      seen_q <= event_tog_i;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (event_tog_i != seen_q) begin
        seen_q <= event_tog_i;
        cnt_q  <= LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign low_o = (cnt_q != '0);

  // R4
  stretch_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
  // R4
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irda_rzi_codec.sv
module irda_rzi_codec
  import irda_codec_pkg::*;
#(
  parameter int unsigned SEL_W         = 3,
  parameter int unsigned PULSE_START   = 8,
  parameter int unsigned PULSE_LEN     = 3,
  parameter int unsigned STRETCH_TICKS = TICKS_PER_BIT,
  parameter int unsigned QUAL_MIN      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_en_i,
  input  logic [SEL_W-1:0] det_div_sel_i,
  input  logic             tick16_i,
  input  logic             tx_bit_i,
  input  logic [PHASE_W-1:0] tx_phase_i,
  output logic             tx_pin_o,
  input  logic             rx_pin_i,
  output logic             rx_bit_o
);
  logic det_strobe;
  logic mod_line;
  logic ev_tog;
  logic stretch_low;

  irda_det_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel_i(det_div_sel_i), .strobe_o(det_strobe)
  );

  irda_tx_shaper #(.PULSE_START(PULSE_START), .PULSE_LEN(PULSE_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .en_i(ir_en_i), .bit_i(tx_bit_i),
    .phase_i(tx_phase_i), .line_o(mod_line)
  );

  irda_rx_qualifier #(.QUAL_MIN(QUAL_MIN)) u_qual (
    .clk(clk), .rst_n(rst_n), .en_i(ir_en_i), .strobe_i(det_strobe),
    .pin_i(rx_pin_i), .event_tog_o(ev_tog)
  );

  irda_rx_stretcher #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
    .clk(clk), .rst_n(rst_n), .en_i(ir_en_i), .tick_i(tick16_i),
    .event_tog_i(ev_tog), .low_o(stretch_low)
  );

  assign tx_pin_o = ir_en_i ? mod_line : tx_bit_i;
  assign rx_bit_o = ir_en_i ? !stretch_low : rx_pin_i;

  // R3
  tx_one_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en_i && tx_bit_i) |=> (tx_pin_o || !ir_en_i));
endmodule

// File: tb/irda_rzi_codec_tb.sv
module irda_rzi_codec_tb_top;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ir_en_i;
  logic [2:0] det_div_sel_i;
  logic       tick16_i = 1'b0;
  logic       tx_bit_i;
  logic [3:0] tx_phase_i = '0;
  logic       tx_pin_o;
  logic       rx_pin_i;
  logic       rx_bit_o;

  always #5 clk = ~clk;

  irda_rzi_codec dut_i (
    .clk(clk), .rst_n(rst_n), .ir_en_i(ir_en_i), .det_div_sel_i(det_div_sel_i),
    .tick16_i(tick16_i), .tx_bit_i(tx_bit_i), .tx_phase_i(tx_phase_i),
    .tx_pin_o(tx_pin_o), .rx_pin_i(rx_pin_i), .rx_bit_o(rx_bit_o)
  );

  int checks = 0;
  int failures = 0;
  int tx_q[$];
  int rx_q[$];
  int sub = 0;
  int ph = 0;
  bit mon_on = 1'b0;
  int tx_run = 0, rx_run = 0, tx_lows = 0, rx_runs = 0;
  int cyc = 0;

  always @(negedge clk) begin
    sub = (sub + 1) % TICK_DIV;
    if (sub == 0) ph = (ph + 1) % 16;
    tick16_i = (sub == 0);
    tx_phase_i = ph[3:0];
  end

  task automatic chk(string r, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", r, got, exp);
    end
  endtask

  // scoreboard monitor: low-run lengths against queued expectations
  always @(negedge clk) if (mon_on) begin
    if (!tx_pin_o) begin
      tx_run++; tx_lows++;
    end else if (tx_run > 0) begin
      if (tx_q.size() == 0) chk("R2_unexpected_tx_run", tx_run, 0);
      else chk("R2_tx_pulse_width", tx_run, tx_q.pop_front());
      tx_run = 0;
    end
    if (!rx_bit_o) begin
      rx_run++;
    end else if (rx_run > 0) begin
      rx_runs++;
      if (rx_q.size() == 0) chk("R4_unexpected_rx_run", rx_run, 0);
      else chk("R4_rx_stretch_width", rx_run, rx_q.pop_front());
      rx_run = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog got=%0d exp=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tick_start();
    do begin @(negedge clk); #1; end while (sub != 0);
  endtask

  task automatic wait_bit_start();
    do begin @(negedge clk); #1; end while (!(sub == 0 && ph == 0));
  endtask

  task automatic send_tx(bit b);
    wait_bit_start();
    tx_bit_i = b;
    if (!b) tx_q.push_back(3 * TICK_DIV);
  endtask

  task automatic rx_pulse(int w, int exp);
    wait_tick_start();
    if (exp > 0) rx_q.push_back(exp);
    rx_pin_i = 1'b0;
    repeat (w) @(negedge clk);
    rx_pin_i = 1'b1;
  endtask

  initial begin
    int runs_before;
    rst_n = 1'b0; ir_en_i = 1'b1; det_div_sel_i = 3'd0;
    tx_bit_i = 1'b1; rx_pin_i = 1'b1;
    idle(5);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1_tx_idle", int'(tx_pin_o), 1);
    chk("R1_rx_idle", int'(rx_bit_o), 1);
    mon_on = 1'b1;

    // R3: ones leave the line high
    send_tx(1'b1); send_tx(1'b1); wait_bit_start();
    chk("R3_no_low_on_ones", tx_lows, 0);

    // R2: zero bits, including adjacent zeros
    send_tx(1'b0); send_tx(1'b1); send_tx(1'b0); send_tx(1'b0); send_tx(1'b1);
    wait_bit_start();
    idle(40);

    // R5 / R4 at divide 1
    runs_before = rx_runs;
    rx_pulse(1, 0); idle(120);
    chk("R5_short_div1_ignored", rx_runs, runs_before);
    rx_pulse(3, 16 * TICK_DIV); idle(120);
    chk("R4_one_stretch_div1", rx_runs, runs_before + 1);

    // R7: second pulse 8 ticks after the first extends the stretch
    wait_tick_start();
    rx_q.push_back(24 * TICK_DIV);
    rx_pin_i = 1'b0; idle(3); rx_pin_i = 1'b1;
    idle(8 * TICK_DIV - 3);
    rx_pin_i = 1'b0; idle(3); rx_pin_i = 1'b1;
    idle(200);
    chk("R7_merged_single_run", rx_runs, runs_before + 2);

    // R6 at divide 4
    det_div_sel_i = 3'd2; idle(10);
    runs_before = rx_runs;
    rx_pulse(3, 0); idle(120);
    chk("R6_short_div4_ignored", rx_runs, runs_before);
    rx_pulse(12, 16 * TICK_DIV); idle(150);
    chk("R6_accept_div4", rx_runs, runs_before + 1);

    // R6 / R9 at divide 128
    det_div_sel_i = 3'd7; idle(10);
    runs_before = rx_runs;
    rx_pulse(100, 0); idle(400);
    chk("R6_short_div128_ignored", rx_runs, runs_before);
    rx_pulse(300, 16 * TICK_DIV); idle(400);
    chk("R9_long_low_one_stretch", rx_runs, runs_before + 1);

    // R8: bypass
    mon_on = 1'b0;
    ir_en_i = 1'b0;
    @(negedge clk); #1;
    rx_pin_i = 1'b0; #1;
    chk("R8_rx_pass_low", int'(rx_bit_o), 0);
    rx_pin_i = 1'b1; #1;
    chk("R8_rx_pass_high", int'(rx_bit_o), 1);
    tx_bit_i = 1'b0; #1;
    chk("R8_tx_pass_low", int'(tx_pin_o), 0);
    tx_bit_i = 1'b1; #1;
    chk("R8_tx_pass_high", int'(tx_pin_o), 1);

    chk("R2_tx_queue_drained", tx_q.size(), 0);
    chk("R4_rx_queue_drained", rx_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule